// File: doc/BRIEF.md
# Lockstep Multi-Converter Serial Capture

This block runs a bank of five dual-output serial analog-to-digital converters as one ten-channel sampler. From the system clock it makes the converter clock, at one fifth of the system rate with three high and two low system cycles per period. Once per frame it issues a single strobe that starts a conversion and opens the read on every converter at once. All converters run off that one strobe, so the ten channels are sampled at the same instant.

While a frame runs, the block shifts in all ten serial streams side by side. A shared counter follows the bits. When the sixteenth bit of a frame is in, the ten words are copied together into one output snapshot, and a one-cycle valid pulse tells a downstream framer that a new set is ready. With a 50 MHz system clock, a frame of 20 converter clocks lasts 2 µs, which gives 500 kS/s per channel.

Top module: `multi_adc_capture`

## Requirements
- R1: `adc_clk` repeats every 5 system clocks. It is high for 3 of them and low for 2. Both levels change only on rising edges of `clk`.
- R2: `conv_strobe` goes high on the same system edge as a rising edge of `adc_clk`. It stays high for exactly one `adc_clk` period (5 system clocks) and rises again every 20 `adc_clk` periods (100 system clocks).
- R3: On the first system edge after reset is released, `adc_clk` and `conv_strobe` both go high.
- R4: Each channel's word is taken MSB first. Bit 15 is the serial line value at the first falling edge of `adc_clk` after `conv_strobe` falls. Each of the next 15 falling edges supplies the next lower bit.
- R5: Channel 2k is output A of converter k (`sdata_a[k]`), and channel 2k+1 is output B (`sdata_b[k]`). The word for channel c sits at `snap_data[16c+15:16c]`.
- R6: Once per frame, `snap_valid` is high for exactly one system cycle. It rises on the first system edge after the edge at which `adc_clk` falls for the sixteenth time in that frame. `snap_data` changes only on that same edge.
- R7: Serial line values at any other time have no effect on the snapshot. This covers values during the strobe, after the sixteenth bit and during the latch cycle.
- R8: While reset is active, `adc_clk`, `conv_strobe` and `snap_valid` are low and `snap_data` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sdata_a | input | NUM_ADC | Serial output A of each converter |
| sdata_b | input | NUM_ADC | Serial output B of each converter |
| adc_clk | output | 1 | Converter clock, system clock divided by 5 |
| conv_strobe | output | 1 | Shared convert-start / read strobe |
| snap_data | output | 2*NUM_ADC*SAMPLE_BITS | Latched snapshot of all channel words |
| snap_valid | output | 1 | One-cycle pulse when the snapshot updates |

## Verification
The cycle that latches the finished words into the snapshot comes right after the last sampling edge. In that cycle the serial lines are free to move, because the converters may already be driving the next value or noise. The bench provokes this by replacing the line values with random bits at once after the sixteenth falling edge. It keeps them random through the latch cycle and the following strobe. It then judges the result by comparing every snapshot with the words it drove, and by checking that `snap_valid` is low one half-cycle after the last sample and high one cycle later.

// File: rtl/madc_pkg.sv
package madc_pkg;

   // Edge events of the converter clock, announced one system cycle early.
   typedef struct packed {
      logic rise;
      logic fall;
   } edge_evt_t;

endpackage

// File: rtl/madc_clk_div.sv
module madc_clk_div #(
   parameter int DIV  = 5,
   parameter int HIGH = 3
) (
   input  logic                clk,
   input  logic                rst_n,
   output logic                adc_clk,
   output madc_pkg::edge_evt_t evt
);
   localparam int CW = $clog2(DIV);
   localparam logic [CW-1:0] LAST  = CW'(DIV - 1);
   localparam logic [CW-1:0] HLAST = CW'(HIGH - 1);
   localparam logic [CW-1:0] HCNT  = CW'(HIGH);
   localparam logic [CW:0]   HRUN  = (CW+1)'(HIGH);

   if (DIV < 2)                  begin : g_bad_div  $error("DIV must be at least 2"); end
   if (HIGH < 1 || HIGH >= DIV)  begin : g_bad_high $error("HIGH must lie in 1..DIV-1"); end

   logic [CW-1:0] phase, phase_nxt;

   always_comb begin
      phase_nxt = (phase == LAST) ? '0 : phase + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase   <= LAST;
         adc_clk <= 1'b0;
      end else begin
         phase   <= phase_nxt;
         adc_clk <= (phase_nxt < HCNT);
      end
   end

   always_comb begin
      evt.rise = (phase == LAST);
      evt.fall = (phase == HLAST);
   end

   // Counts how many cycles the converter clock has been high so far.
   logic [CW:0] hi_run;
   always_ff @(posedge clk) begin
      if (!rst_n)       hi_run <= '0;
      else if (adc_clk) hi_run <= hi_run + 1'b1;
      else              hi_run <= '0;
   end

   assert_high_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
      adc_clk |-> hi_run < HRUN);
   assert_high_len_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(adc_clk) |-> hi_run == HRUN);
   assert_rise_evt_R1: assert property (@(posedge clk) disable iff (!rst_n)
      evt.rise |=> $rose(adc_clk));

endmodule

// File: rtl/madc_seq.sv
module madc_seq #(
   parameter int FRAME = 20,
   parameter int BITS  = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                adc_clk,
   input  madc_pkg::edge_evt_t evt,
   output logic                conv_strobe,
   output logic                sample_en,
   output logic                latch
);
   localparam int FW = $clog2(FRAME);
   localparam int BW = $clog2(BITS + 1);
   localparam logic [FW-1:0] LASTC = FW'(FRAME - 1);
   localparam logic [FW-1:0] BITC  = FW'(BITS);
   localparam logic [BW-1:0] BITSB = BW'(BITS);

   if (FRAME <= BITS + 1) begin : g_bad_frame $error("FRAME must exceed BITS+1"); end

   logic [FW-1:0] cyc;
   logic [BW-1:0] bcnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cyc         <= LASTC;
         conv_strobe <= 1'b0;
      end else if (evt.rise) begin
         cyc         <= (cyc == LASTC) ? '0 : cyc + 1'b1;
         conv_strobe <= (cyc == LASTC);
      end
   end

   // Bits are taken on falling converter edges in cycles 1..BITS of the frame.
   always_comb begin
      sample_en = evt.fall && (cyc != '0) && (cyc <= BITC);
      latch     = (bcnt == BITSB);
   end

   always_ff @(posedge clk) begin
      if (!rst_n)         bcnt <= '0;
      else if (latch)     bcnt <= '0;
      else if (sample_en) bcnt <= bcnt + 1'b1;
   end

   assert_strobe_align_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(conv_strobe) |-> $rose(adc_clk));
   assert_no_sample_in_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
      sample_en |-> !conv_strobe);
   assert_bit_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
      bcnt <= BITSB);
   assert_latch_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
      latch |=> !latch);

endmodule

// File: rtl/madc_lane.sv
module madc_lane #(
   parameter int BITS = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            shift_en,
   input  logic            sdata,
   output logic [BITS-1:0] word
);
   if (BITS < 2) begin : g_bad_bits $error("BITS must be at least 2"); end

   always_ff @(posedge clk) begin
      if (!rst_n)        word <= '0;
      else if (shift_en) word <= {word[BITS-2:0], sdata};
   end

   assert_shift_in_R4: assert property (@(posedge clk) disable iff (!rst_n)
      shift_en |=> word[0] == $past(sdata));
   assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !shift_en |=> $stable(word));

endmodule

// File: rtl/multi_adc_capture.sv
module multi_adc_capture #(
   parameter int NUM_ADC      = 5,
   parameter int SAMPLE_BITS  = 16,
   parameter int CLK_DIV      = 5,
   parameter int CLK_HIGH     = 3,
   parameter int FRAME_CYCLES = 20
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic [NUM_ADC-1:0]                 sdata_a,
   input  logic [NUM_ADC-1:0]                 sdata_b,
   output logic                               adc_clk,
   output logic                               conv_strobe,
   output logic [2*NUM_ADC*SAMPLE_BITS-1:0]   snap_data,
   output logic                               snap_valid
);
   localparam int NUM_CH = 2 * NUM_ADC;

   if (NUM_ADC < 1) begin : g_bad_num $error("NUM_ADC must be at least 1"); end

   madc_pkg::edge_evt_t evt;
   logic sample_en;
   logic latch;

   madc_clk_div #(.DIV(CLK_DIV), .HIGH(CLK_HIGH)) u_div (
      .clk     (clk),
      .rst_n   (rst_n),
      .adc_clk (adc_clk),
      .evt     (evt)
   );

   madc_seq #(.FRAME(FRAME_CYCLES), .BITS(SAMPLE_BITS)) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .adc_clk     (adc_clk),
      .evt         (evt),
      .conv_strobe (conv_strobe),
      .sample_en   (sample_en),
      .latch       (latch)
   );

   logic [SAMPLE_BITS-1:0] words [NUM_CH];

   for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_lane
      logic sd;
      if (ch % 2 == 0) begin : g_a
         assign sd = sdata_a[ch/2];
      end else begin : g_b
         assign sd = sdata_b[ch/2];
      end
      madc_lane #(.BITS(SAMPLE_BITS)) u_lane (
         .clk      (clk),
         .rst_n    (rst_n),
         .shift_en (sample_en),
         .sdata    (sd),
         .word     (words[ch])
      );
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         snap_data  <= '0;
         snap_valid <= 1'b0;
      end else begin
         snap_valid <= latch;
         if (latch) begin
            for (int ch = 0; ch < NUM_CH; ch++) begin
               snap_data[ch*SAMPLE_BITS +: SAMPLE_BITS] <= words[ch];
            end
         end
      end
   end

   assert_valid_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
      snap_valid |=> !snap_valid);
   assert_snap_only_on_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(snap_data) |-> snap_valid);
   assert_valid_after_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(snap_valid) |-> !adc_clk);

endmodule

// File: tb/test_multi_adc_capture.sv
module test_multi_adc_capture;
   localparam int CLK_PERIOD = 20;
   localparam int NADC       = 5;
   localparam int NCH        = 2 * NADC;
   localparam int SB         = 16;
   localparam int NFR        = 6;
   localparam int VW         = NCH * SB;

   logic            clk = 1'b0;
   logic            rst_n;
   logic [NADC-1:0] sdata_a, sdata_b;
   logic            adc_clk, conv_strobe, snap_valid;
   logic [VW-1:0]   snap_data;

   always #(CLK_PERIOD/2) clk = ~clk;

   multi_adc_capture i_multi_adc_capture (
      .clk         (clk),
      .rst_n       (rst_n),
      .sdata_a     (sdata_a),
      .sdata_b     (sdata_b),
      .adc_clk     (adc_clk),
      .conv_strobe (conv_strobe),
      .snap_data   (snap_data),
      .snap_valid  (snap_valid)
   );

   int total = 0, bad = 0, nframes = 0;
   bit finished = 0;
   logic [VW-1:0] expq [$];

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [VW-1:0] act, input logic [VW-1:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   function automatic logic [SB-1:0] pattern(input int f, input int c);
      case (f)
         0:       return 16'hFFFF;
         1:       return (c % 2 == 0) ? 16'h8000 : 16'h0001;
         2:       return 16'hA5C3 ^ SB'(c * 16'h1111);
         default: return SB'($urandom);
      endcase
   endfunction

   // Driver: waits for each strobe fall, pushes the expected snapshot, shifts words MSB first.
   initial begin : driver
      logic [VW-1:0] vec;
      bit seen;
      sdata_a = '0;
      sdata_b = '0;
      @(posedge rst_n);
      for (int f = 0; f < NFR; f++) begin
         seen = 0;
         forever begin
            @(posedge clk);
            #1;
            if (seen && !conv_strobe) break;
            if (conv_strobe) seen = 1;
            sdata_a = NADC'($urandom);   // R7: noise outside the bit window
            sdata_b = NADC'($urandom);
         end
         for (int c = 0; c < NCH; c++) vec[c*SB +: SB] = pattern(f, c);
         expq.push_back(vec);
         for (int b = SB - 1; b >= 0; b--) begin
            for (int k = 0; k < NADC; k++) begin
               sdata_a[k] = vec[(2*k)*SB + b];      // R5: even channel = A
               sdata_b[k] = vec[(2*k+1)*SB + b];    // R5: odd channel = B
            end
            @(negedge adc_clk);
            #1;
         end
         sdata_a = NADC'($urandom);   // R7: noise through the latch cycle
         sdata_b = NADC'($urandom);
         @(negedge clk);
         chk(snap_valid == 1'b0, "R6", "valid before latch edge", VW'(snap_valid), '0);
         @(negedge clk);
         chk(snap_valid == 1'b1, "R6", "valid one cycle after last bit", VW'(snap_valid), VW'(1));
      end
   end

   // Monitor: compares each snapshot with the scoreboard queue (R4, R5, R7).
   initial begin : monitor
      logic [VW-1:0] prev, exp;
      prev = '0;
      @(posedge rst_n);
      forever begin
         @(negedge clk);
         if (snap_valid) begin
            if (expq.size() == 0) begin
               chk(0, "R6", "unexpected snapshot", snap_data, '0);
            end else begin
               exp = expq.pop_front();
               chk(snap_data == exp, "R4", "snapshot words", snap_data, exp);
            end
            nframes++;
         end else if (snap_data !== prev) begin
            chk(0, "R6", "snapshot moved without valid", snap_data, prev);
         end
         prev = snap_data;
      end
   end

   // Timing monitor for the converter clock (R1) and strobe (R2).
   initial begin : timing
      int hi = 0, lo = 0, shi = 0, sper = 0;
      bit sprev = 0, sseen = 0;
      @(posedge rst_n);
      forever begin
         @(negedge clk);
         if (adc_clk) begin
            if (lo > 0) chk(lo == 2, "R1", "adc_clk low run", VW'(lo), VW'(2));
            lo = 0; hi++;
         end else begin
            if (hi > 0) chk(hi == 3, "R1", "adc_clk high run", VW'(hi), VW'(3));
            hi = 0; lo++;
         end
         sper++;
         if (conv_strobe && !sprev) begin
            chk(adc_clk == 1'b1, "R2", "strobe rises with adc_clk", VW'(adc_clk), VW'(1));
            if (sseen) chk(sper == 100, "R2", "strobe period", VW'(sper), VW'(100));
            sseen = 1; sper = 0;
         end
         if (conv_strobe) shi++;
         else if (sprev) begin
            chk(shi == 5, "R2", "strobe width", VW'(shi), VW'(5));
            shi = 0;
         end
         sprev = conv_strobe;
      end
   end

   initial begin : main
      rst_n = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk(adc_clk == 1'b0,     "R8", "reset adc_clk",  VW'(adc_clk), '0);
      chk(conv_strobe == 1'b0, "R8", "reset strobe",   VW'(conv_strobe), '0);
      chk(snap_valid == 1'b0,  "R8", "reset valid",    VW'(snap_valid), '0);
      chk(snap_data == '0,     "R8", "reset snapshot", snap_data, '0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(adc_clk == 1'b1,     "R3", "first adc_clk rise", VW'(adc_clk), VW'(1));
      chk(conv_strobe == 1'b1, "R3", "first strobe",       VW'(conv_strobe), VW'(1));
      wait (nframes == NFR);
      repeat (5) @(posedge clk);
      chk(expq.size() == 0, "R6", "all frames delivered", VW'(expq.size()), '0);
      finish_run();
   end

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      chk(0, "R6", "watchdog expired", VW'(nframes), VW'(NFR));
      finish_run();
   end

endmodule